// File: doc/BRIEF.md
# Dual-Stream Merger With 4b/5b NRZI Framing

This block takes two serial readout streams, A and B, and folds them into a single line-coded output. On each input bit-enable it takes one bit from each stream. The B bit is inverted and placed first, and the A bit follows it. Two such pairs make a 4-bit nibble. A nibble is not encoded until the one after it has arrived. The block then maps it to a 5-bit code and sends the code MSB first as NRZI levels, one level per line bit-enable.

The lookahead serves the framing rule. Symbols whose line levels form 11011 with a 0 on each side, or 00100 with a 1 on each side, become a solid run of five equal levels. A digitizer can lock onto these runs to find symbol boundaries. When both streams sit at 0 the merged stream is all nibble A, and the output turns into alternating runs of five ones and five zeros. That pattern is the idle framing sequence.

The surrounding system supplies the two bit-enables in a fixed ratio: two input enables for every five line enables, with the nibble completing before the symbol boundary. Clock-domain crossing and physical serialization are outside the block.

Top module: `dual_stream_merger`

## Requirements
- R1: While rst_ni is low and after its release, before any line enable, line_o is 0.
- R2: On each input enable the merged stream gains ~b_i then a_i. The first merged bit of a nibble is its bit 3, so a nibble is {~b0, a0, ~b1, a1} for two consecutive enables.
- R3: Nibbles map to codes as 0=11110, 1=01001, 2=10100, 3=10101, 4=01010, 5=01011, 6=01110, 7=01111, 8=10010, 9=10011, A=10110, B=10111, C=11010, D=11011, E=11100, F=11101.
- R4: Codes leave MSB first, one bit per line enable, in 5-enable symbol slots counted from reset. A nibble is encoded in the slot after the one in which its successor nibble completes. The two slots after reset carry the encoding of nibble 0.
- R5: NRZI: on each line enable line_o toggles for a code bit of 1 and holds for a 0.
- R6: A symbol whose line levels are 11011, preceded by line level 0 and followed by a next-symbol first level 0, goes out as 11111. Levels 00100 with both neighbours 1 go out as 00000. This happens for nibble A followed by 0, 2, 3 or 8 to F. No run of equal line levels exceeds five.
- R7: Nibble A followed by 1 or by 4 to 7 is sent unchanged as its plain NRZI code.
- R8: With a_i and b_i held at 0, after the pipeline fills every symbol is five equal levels, opposite to the previous symbol.
- R9: While line_en_i and in_en_i are low, line_o holds and a_i/b_i are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_en_i | input | 1 | Take one bit from each input stream |
| a_i | input | 1 | Stream A data bit |
| b_i | input | 1 | Stream B data bit (inverted inside) |
| line_en_i | input | 1 | Emit one line bit |
| line_o | output | 1 | NRZI line level |

## Verification
The bench targets the framing boundary. Nibble A is followed both by successors that start with a 1 code bit and by ones that start with 0. A lookahead that was wrong or missing would either frame A before 1 or 4 to 7, producing six equal levels, or send plain A where a run of five is due. It also drives asymmetric bit patterns, where swapping the stream order or dropping the B inversion corrupts every nibble. A stall with toggling inputs and an idle run check that the output freezes and that the alternating five-level runs appear.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  localparam int NIB_W = 4;
  localparam int SYM_W = 5;
  localparam logic [NIB_W-1:0] FRAME_NIB  = 4'hA;
  // 10000 under NRZI yields five equal levels, matching the line substitution
  localparam logic [SYM_W-1:0] FRAME_CODE = 5'b10000;

  function automatic logic [SYM_W-1:0] enc_4b5b(input logic [NIB_W-1:0] n);
    logic [SYM_W-1:0] c;
    case (n)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/dsm_interleave.sv
module dsm_interleave #(
  parameter int NIB_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_en_i,
  input  logic             a_i,
  input  logic             b_i,
  output logic [NIB_W-1:0] nib_o,
  output logic             nib_vld_o
);
  localparam int PAIRS = NIB_W / 2;
  localparam int CW    = (PAIRS > 1) ? $clog2(PAIRS) : 1;

  logic [NIB_W-3:0] acc_q;
  logic [CW-1:0]    pair_q;
  logic [NIB_W-1:0] merged;

  // inverted B leads each pair
  assign merged = {acc_q, ~b_i, a_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      pair_q    <= '0;
      nib_o     <= '0;
      nib_vld_o <= 1'b0;
    end else begin
      nib_vld_o <= 1'b0;
      if (in_en_i) begin
        acc_q <= merged[NIB_W-3:0];
        if (pair_q == CW'(PAIRS-1)) begin
          pair_q    <= '0;
          nib_o     <= merged;
          nib_vld_o <= 1'b1;
        end else begin
          pair_q <= pair_q + 1'b1;
        end
      end
    end
  end

  // R2
  nib_after_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_vld_o |-> $past(in_en_i));
endmodule

// File: rtl/dsm_encode.sv
module dsm_encode
  import dsm_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int SYM_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NIB_W-1:0] nib_i,
  input  logic             nib_vld_i,
  output logic [SYM_W-1:0] sym_o
);
  logic [NIB_W-1:0] cur_q, nxt_q;
  logic [SYM_W-1:0] nxt_code;
  logic             frame;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      nxt_q <= '0;
    end else if (nib_vld_i) begin
      cur_q <= nxt_q;
      nxt_q <= nib_i;
    end
  end

  assign nxt_code = enc_4b5b(nxt_q);
  // successor code starting with 1 puts the required neighbour level after the symbol
  assign frame    = (cur_q == FRAME_NIB) && nxt_code[SYM_W-1];
  assign sym_o    = frame ? FRAME_CODE : enc_4b5b(cur_q);

  // R4
  lookahead_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_vld_i |=> (cur_q == $past(nxt_q)));
endmodule

// File: rtl/dsm_nrzi_ser.sv
module dsm_nrzi_ser #(
  parameter int SYM_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_en_i,
  input  logic [SYM_W-1:0] sym_i,
  output logic             line_o
);
  localparam int CW = $clog2(SYM_W);

  logic [SYM_W-1:0] sr_q;
  logic [CW-1:0]    cnt_q;
  logic             lvl_q;
  logic             bit_now;

  assign bit_now = (cnt_q == '0) ? sym_i[SYM_W-1] : sr_q[SYM_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (line_en_i) begin
      sr_q  <= (cnt_q == '0) ? {sym_i[SYM_W-2:0], 1'b0} : {sr_q[SYM_W-2:0], 1'b0};
      cnt_q <= (cnt_q == CW'(SYM_W-1)) ? '0 : cnt_q + 1'b1;
      lvl_q <= lvl_q ^ bit_now;
    end
  end

  assign line_o = lvl_q;

  // R5
  zero_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_en_i && !bit_now) |=> $stable(line_o));
  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_en_i |=> $stable(line_o));
endmodule

// File: rtl/dual_stream_merger.sv
module dual_stream_merger
  import dsm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_en_i,
  input  logic a_i,
  input  logic b_i,
  input  logic line_en_i,
  output logic line_o
);
  logic [NIB_W-1:0] nib;
  logic             nib_vld;
  logic [SYM_W-1:0] sym;

  dsm_interleave #(.NIB_W(NIB_W)) u_ilv (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_en_i(in_en_i),
    .a_i(a_i), .b_i(b_i), .nib_o(nib), .nib_vld_o(nib_vld)
  );

  dsm_encode #(.NIB_W(NIB_W), .SYM_W(SYM_W)) u_enc (
    .clk_i(clk_i), .rst_ni(rst_ni), .nib_i(nib),
    .nib_vld_i(nib_vld), .sym_o(sym)
  );

  dsm_nrzi_ser #(.SYM_W(SYM_W)) u_ser (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_en_i(line_en_i),
    .sym_i(sym), .line_o(line_o)
  );

  // run-length monitor on emitted line levels
  logic       le_q, last_q;
  logic [2:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      le_q   <= 1'b0;
      last_q <= 1'b0;
      run_q  <= '0;
    end else begin
      le_q <= line_en_i;
      if (le_q) begin
        last_q <= line_o;
        if (line_o == last_q) run_q <= (run_q == 3'd7) ? run_q : run_q + 1'b1;
        else                  run_q <= 3'd1;
      end
    end
  end

  // R6
  max_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= 3'd5);
endmodule

// File: tb/dual_stream_merger_tb_top.sv
module dual_stream_merger_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_en = 1'b0, a = 1'b0, b = 1'b0, line_en = 1'b0;
  logic line;

  int n_chk = 0;
  int n_bad = 0;

  logic [3:0] m_cur = 4'h0, m_nxt = 4'h0;
  logic       m_lvl = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_stream_merger dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .in_en_i(in_en), .a_i(a), .b_i(b),
    .line_en_i(line_en), .line_o(line)
  );

  function automatic logic [4:0] ref_code(input logic [3:0] n);
    case (n)
      4'h0: return 5'b11110;  4'h1: return 5'b01001;
      4'h2: return 5'b10100;  4'h3: return 5'b10101;
      4'h4: return 5'b01010;  4'h5: return 5'b01011;
      4'h6: return 5'b01110;  4'h7: return 5'b01111;
      4'h8: return 5'b10010;  4'h9: return 5'b10011;
      4'hA: return 5'b10110;  4'hB: return 5'b10111;
      4'hC: return 5'b11010;  4'hD: return 5'b11011;
      4'hE: return 5'b11100;  default: return 5'b11101;
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: line_o=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // one 5-cycle slot: feeds nibble nib, checks the symbol leaving in this slot
  task automatic feed_frame(input logic [3:0] nib, input string tag, output logic [4:0] obs);
    logic [4:0] code, exp;
    logic l, nxt_first;
    code = ref_code(m_cur);
    l = m_lvl;
    for (int i = 0; i < 5; i++) begin
      l = l ^ code[4-i];
      exp[4-i] = l;
    end
    nxt_first = l ^ ref_code(m_nxt)[4];
    if (exp == 5'b11011 && m_lvl == 1'b0 && nxt_first == 1'b0) exp = 5'b11111;
    if (exp == 5'b00100 && m_lvl == 1'b1 && nxt_first == 1'b1) exp = 5'b00000;
    for (int p = 0; p < 5; p++) begin
      @(negedge clk);
      line_en = 1'b1;
      in_en   = (p == 0) || (p == 2);
      if (p == 0) begin b = ~nib[3]; a = nib[2]; end
      else if (p == 2) begin b = ~nib[1]; a = nib[0]; end
      else begin b = 1'bx; a = 1'bx; end
      @(posedge clk);
      #(CLK_PERIOD/4);
      obs[4-p] = line;
      check(tag, line, exp[4-p]);
    end
    m_lvl = l;
    m_cur = m_nxt;
    m_nxt = nib;
  endtask

  task automatic t_reset();
    #(CLK_PERIOD*2);
    check("R1", line, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check("R1", line, 1'b0);
  endtask

  task automatic t_table();
    logic [4:0] o;
    for (int n = 0; n < 16; n++) feed_frame(4'(n), "R3", o);
    feed_frame(4'h0, "R5", o);
    feed_frame(4'h0, "R4", o);
  endtask

  task automatic t_order();
    logic [4:0] o;
    feed_frame(4'h6, "R2", o); feed_frame(4'h9, "R2", o);
    feed_frame(4'h3, "R2", o); feed_frame(4'hC, "R2", o);
    feed_frame(4'h1, "R2", o); feed_frame(4'h8, "R2", o);
  endtask

  task automatic t_frame_on();
    logic [4:0] o;
    logic [3:0] succ [6] = '{4'h0, 4'h2, 4'h3, 4'h8, 4'hF, 4'hA};
    foreach (succ[k]) begin
      feed_frame(4'hA, "R6", o);
      feed_frame(succ[k], "R6", o);
    end
    feed_frame(4'h5, "R6", o); feed_frame(4'h5, "R6", o);
  endtask

  task automatic t_frame_off();
    logic [4:0] o;
    logic [3:0] succ [5] = '{4'h1, 4'h4, 4'h5, 4'h6, 4'h7};
    foreach (succ[k]) begin
      feed_frame(4'hA, "R7", o);
      feed_frame(succ[k], "R7", o);
    end
    feed_frame(4'h0, "R7", o); feed_frame(4'h0, "R7", o);
  endtask

  task automatic t_stall();
    logic [4:0] o;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      in_en = 1'b0; line_en = 1'b0;
      a = c[0]; b = ~c[0];
      @(posedge clk);
      #(CLK_PERIOD/4);
      check("R9", line, m_lvl);
    end
    feed_frame(4'h7, "R9", o);
    feed_frame(4'hB, "R9", o);
    feed_frame(4'h2, "R9", o);
  endtask

  task automatic t_idle();
    logic [4:0] o, prev;
    feed_frame(4'hA, "R8", o);
    feed_frame(4'hA, "R8", o);
    feed_frame(4'hA, "R8", prev);
    for (int k = 0; k < 6; k++) begin
      feed_frame(4'hA, "R8", o);
      n_chk++;
      if (!(o == 5'b11111 || o == 5'b00000) || o[0] == prev[0]) begin
        n_bad++;
        $display("FAIL R8: symbol=%b expected=%b", o, {5{~prev[0]}});
      end
      prev = o;
    end
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_bad++;
    $display("FAIL watchdog: run=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_table();
    t_order();
    t_frame_on();
    t_frame_off();
    t_stall();
    t_idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule